// File: doc/BRIEF.md
# Configuration Command and Status Register Block

This block holds the 16-bit command register and the 16-bit status register of a 32-bit local-bus function's configuration header. Both sit in the dword at index 1, which is byte offset 04h. The command register sits in the low half of that dword and the status register in the high half.

Configuration writes carry four byte enables, and only the enabled bytes are written. Configuration reads return a whole dword, chosen by the dword index. The read path is combinational: read data follows the dword index in the same cycle.

The command enables go out to the rest of the interface. The three enables that decide whether the function takes part in I/O, memory and bus-master traffic also gate the claim and request strobes. A command value of zero therefore detaches the function from all traffic except configuration accesses.

The target and master logic send one-cycle event pulses that set sticky status flags. Software clears a flag by writing a one to it. Fixed capability bits, the DEVSEL timing code and the identification constants are reported read-only.

Top module: `cfg_cmdsts`

## Requirements
- R1: While rst_ni is low, every writable command bit and every status flag is zero. A read of dword 1 then returns only the read-only status fields.
- R2: A write to dword 1 takes effect at the next rising clock edge. Enable bit cfg_be_i[0] writes command bits 7:0 and enable bit cfg_be_i[1] writes command bits 15:8. A byte whose enable is low keeps its value.
- R3: Command bits 15:10 always read zero and cannot be stored. Any bit of 9:0 that is cleared in parameter CMD_WMASK also always reads zero and cannot be stored.
- R4: cmd_o[9:0] mirrors the stored command bits with this mapping:
  - 0: I/O decode enable
  - 1: memory decode enable
  - 2: bus master enable
  - 3: special cycle response
  - 4: memory-write-and-invalidate enable
  - 5: palette snoop
  - 6: parity error response
  - 7: wait cycle control
  - 8: system error driver enable
  - 9: fast back-to-back enable
- R5: Three strobes are gated by command bits:
  - io_claim_o is io_hit_i AND command bit 0.
  - mem_claim_o is mem_hit_i AND command bit 1.
  - mst_req_o is mst_req_i AND command bit 2.
  
  With the command at 0000h all three strobes stay low.
- R6: evt_i[5:0] is a set of event pulses. A high level on a pulse sets its flag at the next clock edge, and the flag stays set. The mapping from pulse to status bit is:

  | Pulse | Status bit | Flag |
  |---|---|---|
  | evt_i[0] | 8 | data parity detected |
  | evt_i[1] | 11 | signaled target abort |
  | evt_i[2] | 12 | received target abort |
  | evt_i[3] | 13 | received master abort |
  | evt_i[4] | 14 | signaled system error |
  | evt_i[5] | 15 | detected parity error |

  A flag at status bit n appears at read bit 16+n.
- R7: A write to dword 1 with cfg_be_i[3] high clears each flag whose data bit is one. Data zeros leave flags unchanged. A write with cfg_be_i[3] low leaves all flags unchanged.
- R8: If an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: The read-only status fields are fixed by parameters and cannot be written:
  - Status bit 5 is CAP_66MHZ.
  - Status bit 7 is CAP_FB2B.
  - Status bits 10:9 are DEVSEL_SPEED, encoded 00 fast, 01 medium, 10 slow.
  - Status bits 4:0 and 6 read zero.
- R10: Configuration reads work whatever the command value is. The read data is:

  | Dword | Bits 31:16 | Bits 23:16 | Bits 15:8 | Bits 7:0 |
  |---|---|---|---|---|
  | 0 | DEVICE_ID | (within 31:16) | VENDOR_ID | (within 15:0) |
  | 2 | CLASS_CODE (31:8) | | | REV_ID |
  | 3 | zero | {MULTI_FUNC, 7'b0} | zero | zero |

  For dword 0, VENDOR_ID fills bits 15:0. For dword 3, bit 23 is MULTI_FUNC. Every other dword reads zero.
- R11: Writes to any dword other than 1 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low bus reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Dword index of the access |
| cfg_be_i | input | 4 | Byte enables, active high |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i |
| evt_i | input | 6 | Status event pulses |
| cmd_o | output | 10 | Command enables |
| io_hit_i | input | 1 | I/O address match from target decode |
| mem_hit_i | input | 1 | Memory address match from target decode |
| mst_req_i | input | 1 | Raw request from master logic |
| io_claim_o | output | 1 | Gated I/O claim |
| mem_claim_o | output | 1 | Gated memory claim |
| mst_req_o | output | 1 | Gated bus request |

## Verification
The bench builds the block with these parameters:
- CMD_WMASK = 03DFh, which removes the palette snoop bit, so an unimplemented command bit is shown to read back zero even after a write of all ones.
- CAP_66MHZ = 1, CAP_FB2B = 0 and DEVSEL_SPEED = medium. Set and clear read-only bits can then be told apart, and a stuck or shifted DEVSEL field shows up.
- MULTI_FUNC = 1 and non-trivial ID constants, so the multi-function bit and every ID byte lane are visible in the read data.

// File: rtl/cfg_cmdsts_pkg.sv
package cfg_cmdsts_pkg;

  localparam int CMD_W     = 16;
  localparam int STS_W     = 16;
  localparam int NUM_FLAGS = 6;
  localparam int CMD_OUT_W = 10;

  localparam logic [CMD_W-1:0] CMD_DEFINED = 16'h03FF;

  localparam int CMD_IO_EN  = 0;
  localparam int CMD_MEM_EN = 1;
  localparam int CMD_MST_EN = 2;

  localparam int STS_66MHZ   = 5;
  localparam int STS_FB2B    = 7;
  localparam int STS_DEVSEL0 = 9;

  localparam int CMDSTS_DWORD = 1;
  localparam int ID_DWORD     = 0;
  localparam int CLASS_DWORD  = 2;
  localparam int HDR_DWORD    = 3;

  typedef enum logic [1:0] {
    DEVSEL_FAST   = 2'b00,
    DEVSEL_MEDIUM = 2'b01,
    DEVSEL_SLOW   = 2'b10
  } devsel_e;

  // status bit position of each sticky flag, by event index
  function automatic int flag_pos(input int idx);
    case (idx)
      0:       flag_pos = 8;
      1:       flag_pos = 11;
      2:       flag_pos = 12;
      3:       flag_pos = 13;
      4:       flag_pos = 14;
      default: flag_pos = 15;
    endcase
  endfunction

endpackage

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg
  import cfg_cmdsts_pkg::*;
#(
  parameter logic [CMD_W-1:0] WMASK = CMD_DEFINED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       be_i,
  input  logic [CMD_W-1:0] wdata_i,
  output logic [CMD_W-1:0] cmd_o
);

  localparam logic [CMD_W-1:0] EFF_MASK = WMASK & CMD_DEFINED;
  localparam int NBYTES = CMD_W / 8;

  logic [7:0] byte_q [NBYTES];

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q[b] <= '0;
      end else if (wr_i && be_i[b]) begin
        byte_q[b] <= wdata_i[b*8 +: 8] & EFF_MASK[b*8 +: 8];
      end
    end
    assign cmd_o[b*8 +: 8] = byte_q[b];
  end

  p_cmd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cmd_o));

  p_cmd_lane_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !be_i[1]) |=> $stable(cmd_o[15:8]));

  p_cmd_rsvd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((cmd_o & ~EFF_MASK) == '0));

endmodule

// File: rtl/cfg_sts_flags.sv
module cfg_sts_flags
  import cfg_cmdsts_pkg::*;
#(
  parameter int N = NUM_FLAGS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  logic flag_q [N];

  for (genvar g = 0; g < N; g++) begin : g_flag
    // set wins over a clearing write in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (evt_i[g]) flag_q[g] <= 1'b1;
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end
    assign flag_o[g] = flag_q[g];

    p_flag_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> flag_o[g]);

    p_flag_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !evt_i[g]) |=> !flag_o[g]);

    p_flag_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[g] && !evt_i[g]) |=> $stable(flag_o[g]));
  end

endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_cmdsts_pkg::*;
#(
  parameter int          ADDR_W       = 6,
  parameter logic [15:0] VENDOR_ID    = 16'h0000,
  parameter logic [15:0] DEVICE_ID    = 16'h0000,
  parameter logic [7:0]  REV_ID       = 8'h00,
  parameter logic [23:0] CLASS_CODE   = 24'h000000,
  parameter logic        MULTI_FUNC   = 1'b0,
  parameter logic        CAP_66MHZ    = 1'b0,
  parameter logic        CAP_FB2B     = 1'b0,
  parameter logic [1:0]  DEVSEL_SPEED = DEVSEL_FAST
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [NUM_FLAGS-1:0] flag_i,
  output logic [31:0]          rdata_o
);

  localparam logic [STS_W-1:0] STS_RO =
      (STS_W'(CAP_66MHZ)    << STS_66MHZ) |
      (STS_W'(CAP_FB2B)     << STS_FB2B)  |
      (STS_W'(DEVSEL_SPEED) << STS_DEVSEL0);

  logic [STS_W-1:0] sts;

  always_comb begin
    sts = STS_RO;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      sts[flag_pos(i)] = flag_i[i];
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(ID_DWORD):     rdata_o = {DEVICE_ID, VENDOR_ID};
      ADDR_W'(CMDSTS_DWORD): rdata_o = {sts, cmd_i};
      ADDR_W'(CLASS_DWORD):  rdata_o = {CLASS_CODE, REV_ID};
      ADDR_W'(HDR_DWORD):    rdata_o = {8'h00, MULTI_FUNC, 7'h00, 16'h0000};
      default:               rdata_o = '0;
    endcase
  end

  p_devsel_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(CMDSTS_DWORD)) |-> (rdata_o[26:25] == DEVSEL_SPEED));

  p_rsvd_sts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(CMDSTS_DWORD)) |-> (rdata_o[20:16] == 5'd0 && !rdata_o[22]));

endmodule

// File: rtl/cfg_cmdsts.sv
module cfg_cmdsts
  import cfg_cmdsts_pkg::*;
#(
  parameter int          ADDR_W       = 6,
  parameter logic [15:0] CMD_WMASK    = 16'h03FF,
  parameter logic [15:0] VENDOR_ID    = 16'h0000,
  parameter logic [15:0] DEVICE_ID    = 16'h0000,
  parameter logic [7:0]  REV_ID       = 8'h00,
  parameter logic [23:0] CLASS_CODE   = 24'h000000,
  parameter logic        MULTI_FUNC   = 1'b0,
  parameter logic        CAP_66MHZ    = 1'b0,
  parameter logic        CAP_FB2B     = 1'b0,
  parameter logic [1:0]  DEVSEL_SPEED = 2'b00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic [5:0]        evt_i,
  output logic [9:0]        cmd_o,
  input  logic              io_hit_i,
  input  logic              mem_hit_i,
  input  logic              mst_req_i,
  output logic              io_claim_o,
  output logic              mem_claim_o,
  output logic              mst_req_o
);

  logic                 wr_hit;
  logic [CMD_W-1:0]     cmd_q;
  logic [NUM_FLAGS-1:0] flag;
  logic [NUM_FLAGS-1:0] clr;

  assign wr_hit = cfg_wr_i && (cfg_addr_i == ADDR_W'(CMDSTS_DWORD));

  // W1C decode: flag at status bit n lives at dword bit 16+n
  always_comb begin
    for (int i = 0; i < NUM_FLAGS; i++) begin
      clr[i] = wr_hit && cfg_be_i[(16 + flag_pos(i)) / 8] && cfg_wdata_i[16 + flag_pos(i)];
    end
  end

  cfg_cmd_reg #(.WMASK(CMD_WMASK)) u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_hit),
    .be_i   (cfg_be_i[1:0]),
    .wdata_i(cfg_wdata_i[15:0]),
    .cmd_o  (cmd_q)
  );

  cfg_sts_flags #(.N(NUM_FLAGS)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (clr),
    .flag_o (flag)
  );

  cfg_rd_mux #(
    .ADDR_W      (ADDR_W),
    .VENDOR_ID   (VENDOR_ID),
    .DEVICE_ID   (DEVICE_ID),
    .REV_ID      (REV_ID),
    .CLASS_CODE  (CLASS_CODE),
    .MULTI_FUNC  (MULTI_FUNC),
    .CAP_66MHZ   (CAP_66MHZ),
    .CAP_FB2B    (CAP_FB2B),
    .DEVSEL_SPEED(DEVSEL_SPEED)
  ) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (cfg_addr_i),
    .cmd_i  (cmd_q),
    .flag_i (flag),
    .rdata_o(cfg_rdata_o)
  );

  assign cmd_o       = cmd_q[CMD_OUT_W-1:0];
  assign io_claim_o  = io_hit_i  && cmd_q[CMD_IO_EN];
  assign mem_claim_o = mem_hit_i && cmd_q[CMD_MEM_EN];
  assign mst_req_o   = mst_req_i && cmd_q[CMD_MST_EN];

  p_detach_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == '0) |-> !(io_claim_o || mem_claim_o || mst_req_o));

  p_other_dw_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_addr_i != ADDR_W'(CMDSTS_DWORD) && evt_i == '0) |=>
      ($stable(cmd_o) && $stable(flag)));

endmodule

// File: tb/cfg_cmdsts_tb.sv
module cfg_cmdsts_tb;

  localparam int ADDR_W = 6;
  localparam logic [31:0] RO_STS = 32'h0220_0000; // 66MHz=1, DEVSEL medium

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_wr = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [3:0]        cfg_be = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic [5:0]        evt = '0;
  logic [9:0]        cmd;
  logic              io_hit = 1'b0, mem_hit = 1'b0, mreq = 1'b0;
  logic              io_claim, mem_claim, mreq_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  cfg_cmdsts #(
    .ADDR_W      (ADDR_W),
    .CMD_WMASK   (16'h03DF),
    .VENDOR_ID   (16'h1D0C),
    .DEVICE_ID   (16'h7E41),
    .REV_ID      (8'h03),
    .CLASS_CODE  (24'h118000),
    .MULTI_FUNC  (1'b1),
    .CAP_66MHZ   (1'b1),
    .CAP_FB2B    (1'b0),
    .DEVSEL_SPEED(2'b01)
  ) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cfg_wr_i   (cfg_wr),
    .cfg_addr_i (cfg_addr),
    .cfg_be_i   (cfg_be),
    .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .evt_i      (evt),
    .cmd_o      (cmd),
    .io_hit_i   (io_hit),
    .mem_hit_i  (mem_hit),
    .mst_req_i  (mreq),
    .io_claim_o (io_claim),
    .mem_claim_o(mem_claim),
    .mst_req_o  (mreq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int dw, input logic [3:0] be, input logic [31:0] d,
                           input logic [5:0] ev = '0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = ADDR_W'(dw); cfg_be = be; cfg_wdata = d; evt = ev;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0; evt = '0;
  endtask

  task automatic cfg_read(input int dw, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = ADDR_W'(dw);
    #2 d = cfg_rdata;
  endtask

  task automatic pulse(input logic [5:0] ev);
    @(negedge clk);
    evt = ev;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    cfg_read(1, d);
    check("R1 reset dword1", d, RO_STS);
    check("R1 reset cmd_o", 32'(cmd), 32'h0);
  endtask

  task automatic t_cmd_write;
    logic [31:0] d;
    cfg_write(1, 4'b0011, 32'h0000_FFFF);
    cfg_read(1, d);
    check("R2 R3 cmd all ones masked", d & 32'hFFFF, 32'h03DF);
    check("R4 cmd_o mirror", 32'(cmd), 32'h03DF);
    cfg_write(1, 4'b0001, 32'h0);
    cfg_read(1, d);
    check("R2 low byte only", d & 32'hFFFF, 32'h0300);
    cfg_write(1, 4'b0010, 32'h0);
    cfg_read(1, d);
    check("R2 high byte cleared", d & 32'hFFFF, 32'h0000);
  endtask

  task automatic t_gating;
    logic [31:0] d;
    io_hit = 1'b1; mem_hit = 1'b1; mreq = 1'b1;
    cfg_write(1, 4'b0001, 32'h0000_0007);
    #2 check("R5 all enabled", {29'd0, io_claim, mem_claim, mreq_o}, 32'h7);
    cfg_write(1, 4'b0001, 32'h0000_0002);
    #2 check("R5 memory only", {29'd0, io_claim, mem_claim, mreq_o}, 32'h2);
    cfg_write(1, 4'b0011, 32'h0);
    #2 check("R5 detached", {29'd0, io_claim, mem_claim, mreq_o}, 32'h0);
    cfg_read(0, d);
    check("R10 id read while detached", d, 32'h7E41_1D0C);
    io_hit = 1'b0; mem_hit = 1'b0; mreq = 1'b0;
  endtask

  task automatic t_events;
    logic [31:0] d;
    pulse(6'b001000);
    cfg_read(1, d);
    check("R6 master abort flag", d & 32'hFFFF_0000, RO_STS | 32'h2000_0000);
    pulse(6'b111111);
    cfg_read(1, d);
    check("R6 all flags", d & 32'hFFFF_0000, 32'hFB20_0000);
    repeat (3) @(negedge clk);
    cfg_read(1, d);
    check("R6 flags sticky", d & 32'hFFFF_0000, 32'hFB20_0000);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    cfg_write(1, 4'b1000, 32'h2000_0000);
    cfg_read(1, d);
    check("R7 clear one flag", d & 32'hFFFF_0000, 32'hDB20_0000);
    cfg_write(1, 4'b1000, 32'h0);
    cfg_read(1, d);
    check("R7 zeros keep flags", d & 32'hFFFF_0000, 32'hDB20_0000);
    cfg_write(1, 4'b0100, 32'hFFFF_0000);
    cfg_read(1, d);
    check("R7 be3 low keeps flags", d & 32'hFFFF_0000, 32'hDB20_0000);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    cfg_write(1, 4'b1000, 32'h2100_0000, 6'b001000);
    cfg_read(1, d);
    check("R8 set beats clear", d & 32'hFFFF_0000, 32'hFB20_0000 & ~32'h0100_0000 | 32'h2000_0000);
  endtask

  task automatic t_ro;
    logic [31:0] d;
    cfg_write(1, 4'b1100, 32'hFFFF_0000);
    cfg_read(1, d);
    check("R9 read-only fields survive", d & 32'hFFFF_0000, RO_STS);
  endtask

  task automatic t_ids;
    logic [31:0] d;
    cfg_read(0, d);  check("R10 dword0", d, 32'h7E41_1D0C);
    cfg_read(2, d);  check("R10 dword2", d, 32'h1180_0003);
    cfg_read(3, d);  check("R10 dword3 multi-function", d, 32'h0080_0000);
    cfg_read(5, d);  check("R10 other dword", d, 32'h0);
  endtask

  task automatic t_other_dw;
    logic [31:0] d;
    cfg_write(1, 4'b0011, 32'h0000_0105);
    pulse(6'b000010);
    cfg_write(0, 4'hF, 32'hFFFF_FFFF);
    cfg_write(3, 4'hF, 32'hFFFF_FFFF);
    cfg_write(2, 4'hF, 32'hFFFF_FFFF);
    cfg_read(1, d);
    check("R11 dword1 untouched", d, RO_STS | 32'h0800_0105);
    cfg_read(0, d);
    check("R11 ids untouched", d, 32'h7E41_1D0C);
  endtask

  task automatic t_reset_mid;
    logic [31:0] d;
    cfg_write(1, 4'b0011, 32'h0000_FFFF);
    pulse(6'b111111);
    @(negedge clk);
    rst_ni = 1'b0;
    #3;
    check("R1 async reset cmd_o", 32'(cmd), 32'h0);
    cfg_addr = ADDR_W'(1);
    #2 check("R1 async reset dword1", cfg_rdata, RO_STS);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_cmd_write();
    t_gating();
    t_events();
    t_w1c();
    t_collision();
    t_ro();
    t_ids();
    t_other_dw();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule